// File: doc/BRIEF.md
# Serial Memory Page Write Sequencer

This block sits behind the serial command decoder of a byte-wide nonvolatile memory. When a write command arrives, the decoder passes on the start address. The sequencer then gathers the following data bytes into a one-page staging buffer. Each byte carries its own "protected" flag, which the decoder derives from the block-protection setting. When chip select rises, the sequencer decides whether to commit the page. If it commits, it copies every staged byte into the byte array, holds a busy flag for a self-timed programming interval, and finally tells the decoder to drop the write-enable latch.

The staging buffer is a page of 2^PAGE_W bytes (32 by default). The page number comes from the upper address bits and stays fixed for the whole command. Only the in-page offset advances after each byte, so a burst longer than one page wraps to the start of the page. The later bytes then replace the earlier ones. Each buffer slot keeps a valid bit, and only valid slots reach the array.

States: IDLE waits for a command. COLLECT stages bytes for a write-enabled command. SKIP swallows a command issued while the latch was clear. COMMIT walks all page slots, one per clock. HOLD runs the programming timer. FINISH is one cycle that requests the latch clear.

Transitions:
- IDLE→COLLECT: on a command while enabled.
- IDLE→SKIP: on a command while disabled.
- COLLECT→COMMIT: on an aligned chip-select rise after at least one byte.
- COLLECT→IDLE: on any other chip-select rise.
- SKIP→IDLE: on a chip-select rise.
- COMMIT→HOLD: after the last slot.
- HOLD→FINISH: when the timer expires.
- FINISH→IDLE: always.

Top module: `pgw_seq`

## Requirements
- R1: After reset, busy, mem_we and wel_clr are all 0.
- R2: The k-th data byte (k counted from 0) of a committed command is written to the address whose upper ADDR_W-PAGE_W bits equal those of cmd_addr and whose low PAGE_W bits equal (cmd_addr low bits + k) modulo 2^PAGE_W.
- R3: When more than 2^PAGE_W bytes are sent, a later byte that lands on an already staged offset replaces the earlier byte, and only the last value reaches the array.
- R4: A commit happens only on a cs_rise pulse with cs_aligned=1 in COLLECT after at least one byte. Any other chip-select rise discards the staged bytes: no array write and no busy. Bytes and chip-select rises outside a command have no effect.
- R5: If wel is 0 when cmd_start is seen, the whole command (its bytes and its chip-select rise) is ignored: no array write, no busy, no wel_clr.
- R6: A byte presented with byte_prot=1 is not written to the array.
- R7: busy goes high in the cycle after the committing cs_rise and stays high for exactly 2^PAGE_W + PROG_CLKS + 1 consecutive cycles. mem_we is only ever 1 while busy is 1.
- R8: wel_clr is a one-cycle pulse in the last busy cycle of every commit, and is never asserted otherwise.
- R9: cmd_start, byte_stb and cs_rise have no effect while busy is 1; the running cycle keeps its length and no extra array write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle pulse: a write command's address is complete |
| cmd_addr | input | ADDR_W | Start byte address of the command |
| wel | input | 1 | Current write-enable latch state |
| byte_stb | input | 1 | One-cycle pulse: a data byte is complete |
| byte_data | input | DATA_W | Data byte |
| byte_prot | input | 1 | Current byte's address is block-protected |
| cs_rise | input | 1 | One-cycle pulse: chip select went high |
| cs_aligned | input | 1 | Chip-select rise fell straight after a full byte |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming cycle in progress |
| wel_clr | output | 1 | Request to clear the write-enable latch |

## Verification
The assertions assume that cs_rise, cmd_start and byte_stb are single-cycle pulses. They also assume that cs_aligned is only relevant in the cycle of cs_rise, and that the decoder never starts a command before the previous chip-select rise. The stimulus raises each strobe for exactly one clock, leaves idle cycles between bytes, and always closes a command with its own chip-select rise before the next one begins. The only exception is the test that deliberately fires a whole command during busy.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_SKIP,
        ST_COMMIT,
        ST_HOLD,
        ST_FINISH
    } pgw_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
// One page of staged bytes, each slot with its own valid bit.
module pgw_page_buf #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_keep,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int DEPTH = 1 << PAGE_W;

    logic [DATA_W-1:0] slot_data [DEPTH];
    logic [DEPTH-1:0]  slot_vld;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_vld[g] <= 1'b0;
            end else if (clear) begin
                slot_vld[g] <= 1'b0;
            end else if (wr_en && wr_idx == PAGE_W'(g)) begin
                slot_vld[g] <= wr_keep;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PAGE_W'(g)) begin
                slot_data[g] <= wr_data;
            end
        end
    end

    assign rd_data  = slot_data[rd_idx];
    assign rd_valid = slot_vld[rd_idx];
endmodule

// File: rtl/pgw_prog_timer.sv
// Programming interval counter: after load, done rises CYCLES-1 clocks later.
module pgw_prog_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] START = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= START;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PAGE_W    = 5,
    parameter int DATA_W    = 8,
    parameter int PROG_CLKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wel,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_prot,
    input  logic              cs_rise,
    input  logic              cs_aligned,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              wel_clr
);
    localparam int BASE_W = ADDR_W - PAGE_W;
    localparam logic [PAGE_W-1:0] LAST_IDX = '1;

    pgw_state_e        state, nxt;
    logic [BASE_W-1:0] base_q;
    logic [PAGE_W-1:0] wptr_q;
    logic [PAGE_W-1:0] cidx_q;
    logic              got_q;
    logic              open_cmd;
    logic              stage_wr;
    logic              tmr_load;
    logic              tmr_done;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;

    assign open_cmd = (state == ST_IDLE) && cmd_start && wel;
    assign stage_wr = (state == ST_COLLECT) && byte_stb;
    assign tmr_load = (state == ST_COMMIT) && (cidx_q == LAST_IDX);

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (cmd_start) nxt = wel ? ST_COLLECT : ST_SKIP;
            ST_COLLECT: if (cs_rise) nxt = (cs_aligned && got_q) ? ST_COMMIT : ST_IDLE;
            ST_SKIP:    if (cs_rise) nxt = ST_IDLE;
            ST_COMMIT:  if (cidx_q == LAST_IDX) nxt = ST_HOLD;
            ST_HOLD:    if (tmr_done) nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Page base, write pointer and commit walk index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            wptr_q <= '0;
            got_q  <= 1'b0;
            cidx_q <= '0;
        end else begin
            if (open_cmd) begin
                base_q <= cmd_addr[ADDR_W-1:PAGE_W];
                wptr_q <= cmd_addr[PAGE_W-1:0];
                got_q  <= 1'b0;
            end else if (stage_wr) begin
                wptr_q <= wptr_q + 1'b1;
                got_q  <= 1'b1;
            end
            cidx_q <= (state == ST_COMMIT) ? cidx_q + 1'b1 : '0;
        end
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        mem_we    = 1'b0;
        wel_clr   = 1'b0;
        mem_addr  = {base_q, cidx_q};
        mem_wdata = rd_data;
        unique case (state)
            ST_COMMIT: begin busy = 1'b1; mem_we = rd_valid; end
            ST_HOLD:   busy = 1'b1;
            ST_FINISH: begin busy = 1'b1; wel_clr = 1'b1; end
            default:   ;
        endcase
    end

    pgw_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (open_cmd),
        .wr_en    (stage_wr),
        .wr_idx   (wptr_q),
        .wr_data  (byte_data),
        .wr_keep  (!byte_prot),
        .rd_idx   (cidx_q),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    pgw_prog_timer #(.CYCLES(PROG_CLKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .done  (tmr_done)
    );
endmodule

// File: rtl/pgw_seq_chk.sv
module pgw_seq_chk #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              cs_aligned,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              wel_clr
);
    // R7: array writes only inside a busy cycle
    a_r7_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7: busy only starts right after an aligned chip-select rise
    a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && cs_aligned));

    // R8: latch clear only during busy, and busy ends right after it
    a_r8_clr_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> busy);

    a_r8_clr_last: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !busy);

    // R2: consecutive array writes stay inside one page
    a_r2_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]));
endmodule

bind pgw_seq pgw_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (cs_rise),
    .cs_aligned (cs_aligned),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .wel_clr    (wel_clr)
);

// File: tb/pgw_seq_test.sv
module pgw_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int PROG = 20;
    localparam int MEMSZ = 1 << AW;
    localparam int BUSY_LEN = 32 + PROG + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, wel = 1'b0, byte_stb = 1'b0, byte_prot = 1'b0;
    logic cs_rise = 1'b0, cs_aligned = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0] byte_data = '0;
    logic mem_we, busy, wel_clr;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;

    int tests = 0, fails = 0;
    int busy_cnt = 0, wclr_cnt = 0, wclr_pos = 0;
    logic [7:0] obs_mem [MEMSZ];
    logic [7:0] exp_mem [MEMSZ];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgw_seq #(.ADDR_W(AW), .PAGE_W(5), .DATA_W(8), .PROG_CLKS(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .wel(wel), .byte_stb(byte_stb), .byte_data(byte_data), .byte_prot(byte_prot),
        .cs_rise(cs_rise), .cs_aligned(cs_aligned), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .wel_clr(wel_clr)
    );

    // Array model and busy monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) obs_mem[mem_addr] = mem_wdata;
            if (busy) busy_cnt = busy_cnt + 1;
            if (wel_clr) begin
                wclr_cnt = wclr_cnt + 1;
                wclr_pos = busy_cnt;
            end
        end
    end

    task automatic check(input bit ok, input int req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_mem(input int req);
        int mism = 0;
        for (int i = 0; i < MEMSZ; i++) if (obs_mem[i] !== exp_mem[i]) mism++;
        check(mism == 0, req, mism, 0);
    endtask

    // Drives one command; updates the expected array when a commit is due
    task automatic run_txn(input logic [10:0] addr, input int n, input logic [7:0] seed,
                           input int pfrom, input bit aligned, input bit en, input int req);
        bit commit = en && aligned && (n > 0);
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = addr; wel = en;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [10:0] a = {addr[10:5], 5'(addr[4:0] + 5'(i))};
            byte_stb = 1'b1; byte_data = seed + 8'(i); byte_prot = (int'(a) >= pfrom);
            if (commit && int'(a) < pfrom) exp_mem[a] = seed + 8'(i);
            @(negedge clk);
            byte_stb = 1'b0;
            @(negedge clk);
        end
        busy_cnt = 0; wclr_cnt = 0; wclr_pos = 0;
        cs_rise = 1'b1; cs_aligned = aligned;
        @(negedge clk);
        cs_rise = 1'b0; cs_aligned = 1'b0;
        check(busy == commit, 7, int'(busy), int'(commit));   // R7 busy starts next cycle
        repeat (BUSY_LEN + 6) @(negedge clk);
        check(busy_cnt == (commit ? BUSY_LEN : 0), 7, busy_cnt, commit ? BUSY_LEN : 0);
        check(wclr_cnt == (commit ? 1 : 0), 8, wclr_cnt, commit ? 1 : 0);
        if (commit) check(wclr_pos == BUSY_LEN, 8, wclr_pos, BUSY_LEN);
        compare_mem(req);
    endtask

    typedef struct packed {
        logic [10:0] addr;
        logic [6:0]  nb;
        logic [7:0]  seed;
        logic [11:0] pfrom;
        logic        al;
        logic        en;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{11'h000, 7'd4,  8'h10, 12'd2048, 1'b1, 1'b1, 4'd2},  // R2 plain page write
        '{11'h03C, 7'd8,  8'h40, 12'd2048, 1'b1, 1'b1, 4'd2},  // R2 low bits wrap in page
        '{11'h105, 7'd40, 8'h80, 12'd2048, 1'b1, 1'b1, 4'd3},  // R3 overrun overwrites
        '{11'h600, 7'd6,  8'h21, 12'h602,  1'b1, 1'b1, 4'd6},  // R6 protected tail
        '{11'h200, 7'd3,  8'h31, 12'd2048, 1'b0, 1'b1, 4'd4},  // R4 misaligned rise
        '{11'h240, 7'd3,  8'h51, 12'd2048, 1'b1, 1'b0, 4'd5},  // R5 latch clear
        '{11'h7FE, 7'd4,  8'h61, 12'd2048, 1'b1, 1'b1, 4'd2},  // R2 top page wrap
        '{11'h300, 7'd0,  8'h71, 12'd2048, 1'b1, 1'b1, 4'd4}   // R4 no data bytes
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin obs_mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0, 1, int'(busy), 0);
        check(mem_we == 0, 1, int'(mem_we), 0);
        check(wel_clr == 0, 1, int'(wel_clr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && mem_we == 0, 1, int'(busy), 0);

        for (int v = 0; v < 8; v++)
            run_txn(VECS[v].addr, int'(VECS[v].nb), VECS[v].seed, int'(VECS[v].pfrom),
                    VECS[v].al, VECS[v].en, int'(VECS[v].req));

        // R4: stray bytes and an aligned rise with no command
        busy_cnt = 0;
        @(negedge clk); byte_stb = 1'b1; byte_data = 8'hEE; byte_prot = 1'b0;
        @(negedge clk); byte_stb = 1'b0; cs_rise = 1'b1; cs_aligned = 1'b1;
        @(negedge clk); cs_rise = 1'b0; cs_aligned = 1'b0;
        repeat (10) @(negedge clk);
        check(busy_cnt == 0, 4, busy_cnt, 0);
        compare_mem(4);

        // R9: a full command fired while busy is ignored
        fork
            run_txn(11'h400, 2, 8'hA1, 2048, 1'b1, 1'b1, 9);
            begin
                repeat (12) @(negedge clk);
                cmd_start = 1'b1; cmd_addr = 11'h420; wel = 1'b1;
                @(negedge clk); cmd_start = 1'b0; byte_stb = 1'b1; byte_data = 8'hCC;
                @(negedge clk); byte_stb = 1'b0; cs_rise = 1'b1; cs_aligned = 1'b1;
                @(negedge clk); cs_rise = 1'b0; cs_aligned = 1'b0;
            end
        join
        check(busy == 0, 9, int'(busy), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule